// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow window onto a bank of internal registers that are wider than the host data path. The host sees eight 16-bit slots: a status word, a fixed revision word, an indirect address word, four staging words and a readback word. The target of an access is named by the indirect address word. Writing that word is what launches the access.

For a write, the host first fills all four staging words and then writes the address with the direction bit clear. Once the access completes, the four words land together in the target register, with word0 in the least significant position. For a read, the host writes the address with the direction bit set and picks one 16-bit word of the target with the two low address bits. When the access completes, that word appears in the readback slot. A wide register is read by repeating the access with each index in turn. A busy flag in the status word covers every access. The internal registers are held in a small register file inside the block. A status bit can clear that register file together with the staging and readback words.

Top module: `ibr_bridge`

## Requirements
- R1: After rst_n is released, the host slots read as follows: status (sel 0) is 0x0018, address (sel 2) is 0, every staging word (sel 3 to 6 for word0 to word3) is 0, and readback (sel 7) is 0. The read data is combinational on bus_sel.
- R2: The revision slot (sel 1) always reads 0x2013 with the default parameters. Its fields are: bit 15 is audio-absent (active-low presence), bits 14:12 are the board revision, bits 7:4 are the major chip revision and bits 3:0 are the minor chip revision. A host write to this slot has no effect.
- R3: A host write to the address slot while idle sets status bit 0 (busy). Busy stays high for exactly BUSY_CYCLES (4) clock cycles and then clears.
- R4: An access whose address has bit 7 = 0 copies staging words 0..3 into bits 15:0, 31:16, 47:32 and 63:48 of the target register when busy clears.
- R5: An access whose address has bit 7 = 1 loads the 16-bit word of the target selected by address bits 1:0 (00 = word0 to 11 = word3) into the readback slot when busy clears. The readback slot changes at no other time, apart from R9.
- R6: The target is decoded from address bits 15:12 (kind), 11:8 (instance) and 3:2 (parameter), and each decoded target is a separate register. The implemented targets are:
  - kind 9, instance 1, parameters 0 to 3;
  - kind 1, instances 1 to 6, parameters 1 and 2;
  - kind 2, instances 1 to 3, parameters 1 and 2;
  - kind 3, instance 1, parameter 1.
- R7: While busy, host writes to the address slot and to the staging slots are ignored.
- R8: An access to an address that is not implemented still runs its full busy period. A write to such an address is dropped, and a read of it returns 0 in the readback slot.
- R9: While status bit 3 (global reset, active-low) is 0, every internal register, every staging word and the readback word are cleared to 0.
- R10: Status bits 2 (quad mode), 3 (global reset_n) and 4 (codec reset_n) are host-writable and read back. Bit 0 reflects busy only and cannot be written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_sel | input | 3 | Host slot select: 0 status, 1 revision, 2 address, 3-6 staging word0-3, 7 readback |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the selected slot |
| quad_mode_o | output | 1 | Codec mode from status bit 2 |
| codec_rst_n_o | output | 1 | Codec section reset from status bit 4 |

## Verification
Write/readback round trips are applied to six targets that span every block kind, with distinct data in each word. This shows that each staging word reaches its own lane and that each index selects the right lane. A later re-read of the first target shows that the targets are decoded separately and do not alias. Unimplemented kinds and instances are tried after a nonzero readback, so a returned zero cannot be confused with a stale value. Writes to the address and staging slots are issued in the middle of a busy period to show that they are dropped. A pulse on the global-reset bit shows that the staging words, the readback word and the register file are all cleared.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
// ibr_pkg: shared types, slot codes and the target decode for the indirect
// register bridge. Assumes a 16-bit host word and four words per target.
package ibr_pkg;

    localparam int WORD_W      = 16;
    localparam int NUM_WORDS   = 4;
    localparam int ENTRY_W     = WORD_W * NUM_WORDS;
    localparam int NUM_TARGETS = 23;
    localparam int IDX_W       = $clog2(NUM_TARGETS);

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_REV    = 3'd1,
        SEL_ADDR   = 3'd2,
        SEL_DATA0  = 3'd3,
        SEL_DATA1  = 3'd4,
        SEL_DATA2  = 3'd5,
        SEL_DATA3  = 3'd6,
        SEL_RBACK  = 3'd7
    } host_sel_e;

    localparam logic [3:0] KIND_DMA = 4'd1;
    localparam logic [3:0] KIND_CLK = 4'd2;
    localparam logic [3:0] KIND_TMR = 4'd3;
    localparam logic [3:0] KIND_GLB = 4'd9;

    typedef struct packed {
        logic [3:0] kind;
        logic [3:0] inst;
        logic       dir_rd;
        logic [2:0] rsvd;
        logic [1:0] param;
        logic [1:0] rb_idx;
    } ind_addr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } target_t;

    // Map an indirect address onto a register-file slot, or flag a miss.
    function automatic target_t decode_target(input ind_addr_t a);
        target_t t;
        t.hit = 1'b0;
        t.idx = '0;
        case (a.kind)
            KIND_GLB: begin
                if (a.inst == 4'd1) begin
                    t.hit = 1'b1;
                    t.idx = IDX_W'(a.param);
                end
            end
            KIND_DMA: begin
                if (a.inst >= 4'd1 && a.inst <= 4'd6 && a.param >= 2'd1 && a.param <= 2'd2) begin
                    t.hit = 1'b1;
                    t.idx = IDX_W'(4) + IDX_W'({a.inst - 4'd1, 1'b0}) + IDX_W'(a.param - 2'd1);
                end
            end
            KIND_CLK: begin
                if (a.inst >= 4'd1 && a.inst <= 4'd3 && a.param >= 2'd1 && a.param <= 2'd2) begin
                    t.hit = 1'b1;
                    t.idx = IDX_W'(16) + IDX_W'({a.inst - 4'd1, 1'b0}) + IDX_W'(a.param - 2'd1);
                end
            end
            KIND_TMR: begin
                if (a.inst == 4'd1 && a.param == 2'd1) begin
                    t.hit = 1'b1;
                    t.idx = IDX_W'(22);
                end
            end
            default: t.hit = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ibr_seq.sv
`timescale 1ns/1ps
// ibr_seq: transaction sequencer. Captures the indirect address on a start
// request while idle, holds busy for BUSY_CYCLES clocks, and pulses commit in
// the last busy cycle. Assumes BUSY_CYCLES >= 1. Starts while busy are dropped.
module ibr_seq #(
    parameter int BUSY_CYCLES = 4,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              commit,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the countdown and address on an idle start, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q  <= CNT_W'(BUSY_CYCLES);
            addr_q <= addr_in;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Busy while counting; commit in the final busy cycle.
    assign busy   = (cnt_q != '0);
    assign commit = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ibr_regfile.sv
`timescale 1ns/1ps
// ibr_regfile: the internal target registers, each ENTRY_W bits wide.
// One whole-entry write port, one combinational read port, and a synchronous
// clear that has priority over writes. Out-of-range read indexes return 0.
module ibr_regfile #(
    parameter int NUM_ENTRIES = 23,
    parameter int ENTRY_W     = 64,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   ridx,
    output logic [ENTRY_W-1:0] rdata
);
    logic [ENTRY_W-1:0] ent_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        // Hold one target register: reset, clear, or take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ent_q[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                ent_q[g] <= wdata;
            end
        end
    end

    // Read port with a range guard.
    always_comb begin
        rdata = '0;
        if (int'(ridx) < NUM_ENTRIES) rdata = ent_q[ridx];
    end

endmodule

// File: rtl/ibr_bridge.sv
`timescale 1ns/1ps
// ibr_bridge: host-facing indirect register bridge. Holds the status,
// address, staging and readback slots, decodes the captured address at commit
// and moves data to or from the register file. Assumes one host write per
// bus_wr cycle and combinational read data selected by bus_sel.
module ibr_bridge #(
    parameter int         BUSY_CYCLES = 4,
    parameter logic       REV_ABSENT  = 1'b0,
    parameter logic [2:0] REV_BOARD   = 3'd2,
    parameter logic [3:0] REV_MAJOR   = 4'd1,
    parameter logic [3:0] REV_MINOR   = 4'd3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [2:0]                bus_sel,
    input  logic [ibr_pkg::WORD_W-1:0] bus_wdata,
    output logic [ibr_pkg::WORD_W-1:0] bus_rdata,
    output logic                      quad_mode_o,
    output logic                      codec_rst_n_o
);
    import ibr_pkg::*;

    localparam logic [WORD_W-1:0] REV_WORD = {REV_ABSENT, REV_BOARD, 4'd0, REV_MAJOR, REV_MINOR};

    logic              quad_q;
    logic              glob_rst_n_q;
    logic              codec_rst_n_q;
    logic              glob_clr;
    logic              busy;
    logic              commit;
    logic              start;
    logic [WORD_W-1:0] addr_q;
    ind_addr_t         cur_addr;
    target_t           tgt;
    logic [WORD_W-1:0] stage_q [NUM_WORDS];
    logic [ENTRY_W-1:0] stage_flat;
    logic [ENTRY_W-1:0] rf_rdata;
    logic [WORD_W-1:0] rb_word;
    logic              rf_we;

    assign glob_clr = !glob_rst_n_q;
    assign start    = bus_wr && (bus_sel == SEL_ADDR);
    assign cur_addr = ind_addr_t'(addr_q);
    assign tgt      = decode_target(cur_addr);
    assign rf_we    = commit && !cur_addr.dir_rd && tgt.hit;

    // Host-writable control bits of the status slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quad_q        <= 1'b0;
            glob_rst_n_q  <= 1'b1;
            codec_rst_n_q <= 1'b1;
        end else if (bus_wr && bus_sel == SEL_STATUS) begin
            quad_q        <= bus_wdata[2];
            glob_rst_n_q  <= bus_wdata[3];
            codec_rst_n_q <= bus_wdata[4];
        end
    end

    ibr_seq #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .ADDR_W      (WORD_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_in (bus_wdata),
        .busy    (busy),
        .commit  (commit),
        .addr_q  (addr_q)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stage
        // Staging word: cleared by global reset, written only while idle.
        always_ff @(posedge clk) begin
            if (!rst_n || glob_clr) begin
                stage_q[w] <= '0;
            end else if (bus_wr && !busy && bus_sel == 3'(int'(SEL_DATA0) + w)) begin
                stage_q[w] <= bus_wdata;
            end
        end
        assign stage_flat[w*WORD_W +: WORD_W] = stage_q[w];
    end

    ibr_regfile #(
        .NUM_ENTRIES (NUM_TARGETS),
        .ENTRY_W     (ENTRY_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (glob_clr),
        .we    (rf_we),
        .widx  (tgt.idx),
        .wdata (stage_flat),
        .ridx  (tgt.idx),
        .rdata (rf_rdata)
    );

    // Readback word: loaded when a read access commits, zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr) begin
            rb_word <= '0;
        end else if (commit && cur_addr.dir_rd) begin
            rb_word <= tgt.hit ? rf_rdata[cur_addr.rb_idx*WORD_W +: WORD_W] : '0;
        end
    end

    // Host read multiplexer.
    always_comb begin
        case (bus_sel)
            SEL_STATUS: bus_rdata = {11'd0, codec_rst_n_q, glob_rst_n_q, quad_q, 1'b0, busy};
            SEL_REV:    bus_rdata = REV_WORD;
            SEL_ADDR:   bus_rdata = addr_q;
            SEL_DATA0:  bus_rdata = stage_q[0];
            SEL_DATA1:  bus_rdata = stage_q[1];
            SEL_DATA2:  bus_rdata = stage_q[2];
            SEL_DATA3:  bus_rdata = stage_q[3];
            default:    bus_rdata = rb_word;
        endcase
    end

    assign quad_mode_o   = quad_q;
    assign codec_rst_n_o = codec_rst_n_q;

endmodule

// File: rtl/ibr_checker.sv
`timescale 1ns/1ps
// ibr_checker: temporal checks on the bridge, bound to ibr_bridge.
// Busy length is measured with a local counter rather than a long delay.
module ibr_checker #(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_sel,
    input logic        busy,
    input logic [15:0] addr_q,
    input logic [15:0] rb_word,
    input logic        glob_rst_n
);
    localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;

    logic [RUN_W-1:0] busy_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd2 && !busy) |=> busy); // R3
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(BUSY_CYCLES)); // R3
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == RUN_W'(BUSY_CYCLES)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_sel == 3'd2) |=> $stable(addr_q)); // R7
    AST_RB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && glob_rst_n) |=> $stable(rb_word)); // R5
    AST_RB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_rst_n |=> rb_word == 16'd0); // R9

endmodule

bind ibr_bridge ibr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .busy       (busy),
    .addr_q     (addr_q),
    .rb_word    (rb_word),
    .glob_rst_n (glob_rst_n_q)
);

// File: tb/ibr_bridge_bench.sv
`timescale 1ns/1ps
module ibr_bridge_bench;
    localparam int BUSY = 4;
    localparam int NV   = 6;
    // {address, word3, word2, word1, word0}
    localparam logic [79:0] VEC [NV] = '{
        {16'h9100, 16'h0D03, 16'hC002, 16'hB001, 16'hA000},
        {16'h910C, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0},
        {16'h1104, 16'h0001, 16'h0020, 16'h0300, 16'h4000},
        {16'h1508, 16'hFFFF, 16'h0000, 16'h8001, 16'h7FFE},
        {16'h2308, 16'h2468, 16'h1357, 16'hACE1, 16'hBD02},
        {16'h3104, 16'h0F0F, 16'hF0F0, 16'h5A5A, 16'hA5A5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        quad_mode_o;
    logic        codec_rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ibr_bridge u_ibr_bridge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .quad_mode_o(quad_mode_o), .codec_rst_n_o(codec_rst_n_o)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        bus_sel = s;
        #1 v = bus_rdata;
    endtask

    task automatic access(input logic [15:0] a);
        wr(3'd2, a);
        repeat (BUSY) @(negedge clk);
    endtask

    task automatic stage(input logic [63:0] d);
        for (int w = 0; w < 4; w++) wr(3'(3 + w), d[w*16 +: 16]);
    endtask

    task automatic read_word(input logic [15:0] a, input int idx, output logic [15:0] v);
        access(a | 16'h0080 | 16'(idx));
        rd(3'd7, v);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, v); chk("R1 status", v, 16'h0018);
        rd(3'd2, v); chk("R1 addr", v, 16'h0000);
        for (int w = 0; w < 4; w++) begin rd(3'(3 + w), v); chk("R1 stage", v, 16'h0000); end
        rd(3'd7, v); chk("R1 rback", v, 16'h0000);

        // R2 revision constant, write ignored
        rd(3'd1, v); chk("R2 rev", v, 16'h2013);
        wr(3'd1, 16'hFFFF);
        rd(3'd1, v); chk("R2 rev after write", v, 16'h2013);

        // R4 R5 R6 table of write/readback round trips
        for (int i = 0; i < NV; i++) begin
            stage(VEC[i][63:0]);
            access(VEC[i][79:64]);
            for (int k = 0; k < 4; k++) begin
                read_word(VEC[i][79:64], k, v);
                chk("R4 R5 readback", v, VEC[i][k*16 +: 16]);
            end
        end
        // R6 first target not aliased by later ones
        read_word(VEC[0][79:64], 2, v); chk("R6 no alias", v, VEC[0][47:32]);

        // R3 busy length
        wr(3'd2, 16'h9180);
        rd(3'd0, v); chk("R3 busy c1", {15'd0, v[0]}, 16'd1);
        for (int c = 2; c <= 5; c++) begin
            @(negedge clk);
            rd(3'd0, v);
            chk("R3 busy window", {15'd0, v[0]}, (c <= BUSY) ? 16'd1 : 16'd0);
        end

        // R7 writes while busy ignored
        stage(64'h4444_3333_2222_1111);
        wr(3'd2, 16'h9104);
        wr(3'd3, 16'hDEAD);
        wr(3'd2, 16'h9108);
        repeat (BUSY - 2) @(negedge clk);
        rd(3'd2, v); chk("R7 addr held", v, 16'h9104);
        rd(3'd3, v); chk("R7 stage held", v, 16'h1111);
        read_word(16'h9104, 0, v); chk("R7 target data", v, 16'h1111);
        read_word(16'h9108, 0, v); chk("R7 second target untouched", v, 16'h0000);

        // R8 unimplemented addresses
        read_word(VEC[1][79:64], 0, v); chk("R8 pre nonzero", v, 16'hDEF0);
        access(16'h4104);
        read_word(16'h4104, 0, v); chk("R8 miss kind", v, 16'h0000);
        read_word(VEC[1][79:64], 1, v);
        access(16'h1704);
        read_word(16'h1704, 1, v); chk("R8 miss inst", v, 16'h0000);

        // R10 status bits
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R10 status rw", v, 16'h001C);
        chk("R10 quad out", {15'd0, quad_mode_o}, 16'd1);
        wr(3'd0, 16'h0008);
        rd(3'd0, v); chk("R10 codec reset", v, 16'h0008);
        chk("R10 codec out", {15'd0, codec_rst_n_o}, 16'd0);
        wr(3'd0, 16'h0018);

        // R9 global reset clears everything
        read_word(VEC[2][79:64], 3, v);
        stage(64'h0BAD_0BAD_0BAD_0BAD);
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0018);
        for (int w = 0; w < 4; w++) begin rd(3'(3 + w), v); chk("R9 stage clear", v, 16'h0000); end
        rd(3'd7, v); chk("R9 rback clear", v, 16'h0000);
        read_word(VEC[2][79:64], 3, v); chk("R9 regfile clear", v, 16'h0000);
        read_word(VEC[5][79:64], 0, v); chk("R9 regfile clear timer", v, 16'h0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule